// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block connects a byte-wide host bus to three parallel ports. Ports A and B are each eight pins wide. Port C is eight pins wide and is handled as two independent four-pin halves. The host uses an active-low chip select, an active-low read strobe, an active-low write strobe and a two-bit register address. With these it can read input pins, read back output latches, load output latches and program a control register. Each of the four port groups (A, B, upper C, lower C) is set as input or output by one control byte. Each pin has its own output-enable line, so the pad ring can build the tri-state drivers. The host data bus is modelled the same way, as a data output with a separate drive-enable.

A control byte with its top bit set defines the mode. A control byte with its top bit clear sets or clears one bit of port C. Only the basic I/O mode is built. A mode byte that asks for a strobed or bidirectional handshake mode is decoded as reserved and is discarded. Writes take effect on the rising clock edge while chip select and the write strobe are both low. Reads are combinational.

Top module: `ppio_ctrl`

## Requirements
- R1: Address 0 selects port A and address 1 selects port B. A read returns the input pins when the group is an input, and the output latch when it is an output.
- R2: A read of address 2 (port C) builds each nibble on its own. Bits 7:4 come from the pins or the latch according to the upper half's direction. Bits 3:0 follow the lower half's direction.
- R3: `bus_oe` is 1 only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. In every other case `bus_oe` is 0 and `bus_dout` is 0.
- R4: Reset clears the stored control state. All groups become inputs (every `*_oe` bit is 0), every output latch is 0, and a control readback gives 0x9B.
- R5: A write to address 3 with bit 7 = 1 and bits 6,5,2 = 0 is a mode definition. Bit 4 sets port A, bit 3 sets port C upper, bit 1 sets port B and bit 0 sets port C lower, where 1 means input. From the next cycle, the oe bits of an output group are all 1 and those of an input group are all 0.
- R6: An accepted mode definition clears all three output latches on the same edge.
- R7: A write to address 3 with bit 7 = 0 loads bit 0 into the port C latch bit chosen by bits 3:1. All other latch bits keep their values.
- R8: A mode byte with bit 7 = 1 and any of bits 6, 5 or 2 set (a handshake mode) is ignored. Directions and latches are unchanged.
- R9: A write to address 0, 1 or 2 loads the full byte into that port's latch. Latches drive `*_out` at all times. No latch or direction changes on an edge unless `cs_n`=0 and `wr_n`=0, and a write with `rd_n` also low still takes place.
- R10: A read of address 3 returns {1, 0, 0, A_in, Cu_in, 0, B_in, Cl_in}, where each bit is 1 for an input group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data, 0 when not driven |
| bus_oe | output | 1 | Host data bus drive enable |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A pin drive enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B pin drive enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C pin drive enable |

## Verification
The bound checker covers the following on every cycle:
- the bus drive rule;
- that each oe vector is uniform across its group;
- what follows an accepted mode byte, a reserved mode byte and a single-bit command on the next cycle;
- that no state moves without a write;
- that an input-mode read returns the pins.

The per-clock reference model in the bench covers the parts a property cannot easily express. These are the full address decode with mixed port C nibbles, the control readback encoding and the reset values. They also include a write with both strobes low and a long randomised mix of bus traffic.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = BYTE_W / 2;

   // address decode
   localparam logic [1:0] SEL_A   = 2'd0;
   localparam logic [1:0] SEL_B   = 2'd1;
   localparam logic [1:0] SEL_C   = 2'd2;
   localparam logic [1:0] SEL_CTL = 2'd3;

   // control byte fields
   localparam int CB_MODE  = 7;
   localparam int CB_DIR_A = 4;
   localparam int CB_DIR_CU = 3;
   localparam int CB_DIR_B = 1;
   localparam int CB_DIR_CL = 0;

   // 1 = group drives its pins
   typedef struct packed {
      logic a;
      logic cu;
      logic b;
      logic cl;
   } grp_drive_t;
endpackage

// File: rtl/ppio_ctl_reg.sv
module ppio_ctl_reg
   import ppio_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [BYTE_W-1:0] wdata,
   output grp_drive_t       drive,
   output logic             latch_clr,
   output logic             bit_en,
   output logic [2:0]       bit_sel,
   output logic             bit_val
);
   logic is_mode;
   logic handshake_req;

   always_comb begin
      is_mode       = wdata[CB_MODE];
      handshake_req = (wdata[6:5] != 2'b00) || wdata[2];
      latch_clr     = ctl_wr && is_mode && !handshake_req;
      bit_en        = ctl_wr && !is_mode;
      bit_sel       = wdata[3:1];
      bit_val       = wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive <= '0;
      end else if (latch_clr) begin
         drive.a  <= ~wdata[CB_DIR_A];
         drive.cu <= ~wdata[CB_DIR_CU];
         drive.b  <= ~wdata[CB_DIR_B];
         drive.cl <= ~wdata[CB_DIR_CL];
      end
   end
endmodule

// File: rtl/ppio_grp_latch.sv
module ppio_grp_latch #(
   parameter int W       = 8,
   parameter int BASE    = 0,
   parameter bit HAS_BIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         bit_en,
   input  logic [2:0]   bit_sel,
   input  logic         bit_val,
   output logic [W-1:0] q
);
   initial begin
      assert (W > 0 && BASE >= 0 && BASE + W <= 8)
         else $fatal(1, "ppio_grp_latch: bad width or base");
   end

   logic [W-1:0] bit_next;

   generate
      if (HAS_BIT) begin : g_bitcmd
         always_comb begin
            bit_next = q;
            for (int i = 0; i < W; i++) begin
               if (int'(bit_sel) == BASE + i) bit_next[i] = bit_val;
            end
         end
      end else begin : g_nobit
         always_comb bit_next = q;
         logic unused_bits;
         assign unused_bits = ^{bit_en, bit_sel, bit_val};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= '0;
      else if (clr)         q <= '0;
      else if (wr_en)       q <= wr_data;
      else if (HAS_BIT && bit_en) q <= bit_next;
   end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
   import ppio_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);
   localparam int HALF = DATA_W / 2;

   initial begin
      assert (DATA_W == BYTE_W) else $fatal(1, "ppio_ctrl: DATA_W must be 8");
      assert (ADDR_W == 2)      else $fatal(1, "ppio_ctrl: ADDR_W must be 2");
   end

   logic       wr_cyc;
   grp_drive_t drive;
   logic       latch_clr, bit_en, bit_val;
   logic [2:0] bit_sel;
   logic [HALF-1:0] pc_hi_q, pc_lo_q;

   assign wr_cyc = !cs_n && !wr_n;

   ppio_ctl_reg u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(wr_cyc && addr == SEL_CTL), .wdata(bus_din),
      .drive(drive), .latch_clr(latch_clr),
      .bit_en(bit_en), .bit_sel(bit_sel), .bit_val(bit_val)
   );

   ppio_grp_latch #(.W(DATA_W), .BASE(0), .HAS_BIT(1'b0)) u_lat_a (
      .clk(clk), .rst_n(rst_n), .clr(latch_clr),
      .wr_en(wr_cyc && addr == SEL_A), .wr_data(bus_din),
      .bit_en(1'b0), .bit_sel(3'd0), .bit_val(1'b0), .q(pa_out)
   );

   ppio_grp_latch #(.W(DATA_W), .BASE(0), .HAS_BIT(1'b0)) u_lat_b (
      .clk(clk), .rst_n(rst_n), .clr(latch_clr),
      .wr_en(wr_cyc && addr == SEL_B), .wr_data(bus_din),
      .bit_en(1'b0), .bit_sel(3'd0), .bit_val(1'b0), .q(pb_out)
   );

   ppio_grp_latch #(.W(HALF), .BASE(HALF), .HAS_BIT(1'b1)) u_lat_cu (
      .clk(clk), .rst_n(rst_n), .clr(latch_clr),
      .wr_en(wr_cyc && addr == SEL_C), .wr_data(bus_din[DATA_W-1:HALF]),
      .bit_en(bit_en), .bit_sel(bit_sel), .bit_val(bit_val), .q(pc_hi_q)
   );

   ppio_grp_latch #(.W(HALF), .BASE(0), .HAS_BIT(1'b1)) u_lat_cl (
      .clk(clk), .rst_n(rst_n), .clr(latch_clr),
      .wr_en(wr_cyc && addr == SEL_C), .wr_data(bus_din[HALF-1:0]),
      .bit_en(bit_en), .bit_sel(bit_sel), .bit_val(bit_val), .q(pc_lo_q)
   );

   assign pc_out = {pc_hi_q, pc_lo_q};
   assign pa_oe  = {DATA_W{drive.a}};
   assign pb_oe  = {DATA_W{drive.b}};
   assign pc_oe  = {{HALF{drive.cu}}, {HALF{drive.cl}}};

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      unique case (addr)
         SEL_A:   rd_mux = drive.a ? pa_out : pa_in;
         SEL_B:   rd_mux = drive.b ? pb_out : pb_in;
         SEL_C:   rd_mux = {drive.cu ? pc_hi_q : pc_in[DATA_W-1:HALF],
                            drive.cl ? pc_lo_q : pc_in[HALF-1:0]};
         default: rd_mux = {1'b1, 2'b00, ~drive.a, ~drive.cu, 1'b0, ~drive.b, ~drive.cl};
      endcase
   end

   assign bus_oe   = !cs_n && !rd_n && wr_n;
   assign bus_dout = bus_oe ? rd_mux : '0;
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       rd_n,
   input logic       wr_n,
   input logic [1:0] addr,
   input logic [7:0] bus_din,
   input logic [7:0] bus_dout,
   input logic       bus_oe,
   input logic [7:0] pa_in,
   input logic [7:0] pa_out,
   input logic [7:0] pa_oe,
   input logic [7:0] pb_out,
   input logic [7:0] pb_oe,
   input logic [7:0] pc_out,
   input logic [7:0] pc_oe
);
   logic ctl_w, mode_ok, mode_rsv, bitcmd, any_w;
   assign any_w    = !cs_n && !wr_n;
   assign ctl_w    = any_w && addr == 2'd3;
   assign mode_ok  = ctl_w && bus_din[7] && bus_din[6:5] == 2'b00 && !bus_din[2];
   assign mode_rsv = ctl_w && bus_din[7] && (bus_din[6:5] != 2'b00 || bus_din[2]);
   assign bitcmd   = ctl_w && !bus_din[7];

   // R3
   assert_bus_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n || !wr_n) |-> (!bus_oe && bus_dout == 8'h00));

   // R5
   assert_oe_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
      (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) && (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

   assert_mode_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ok |=> (pa_oe[0] == !$past(bus_din[4]) && pc_oe[4] == !$past(bus_din[3]) &&
                   pb_oe[0] == !$past(bus_din[1]) && pc_oe[0] == !$past(bus_din[0])));

   // R6
   assert_mode_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ok |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

   // R7
   assert_bit_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bitcmd |=> (pc_out[$past(bus_din[3:1])] == $past(bus_din[0])));

   // R8
   assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_rsv |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                    $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

   // R9
   assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !any_w |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                  $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

   // R1
   assert_read_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && addr == 2'd0 && pa_oe == 8'h00) |-> bus_dout == pa_in);
endmodule

bind ppio_ctrl ppio_ctrl_chk i_chk (.*);

// File: tb/test_ppio_ctrl.sv
`timescale 1ns/1ps
module test_ppio_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] bus_din = 8'h00;
   logic [7:0] bus_dout;
   logic       bus_oe;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ppio_ctrl i_ppio_ctrl (.*);

   // reference model: 1 = input
   bit       m_ia = 1, m_ib = 1, m_icu = 1, m_icl = 1;
   bit [7:0] m_la = 0, m_lb = 0, m_lc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ia = 1; m_ib = 1; m_icu = 1; m_icl = 1;
         m_la = 0; m_lb = 0; m_lc = 0;
      end else if (cs_n == 1'b0 && wr_n == 1'b0) begin
         if (addr == 2'd0) m_la = bus_din;
         else if (addr == 2'd1) m_lb = bus_din;
         else if (addr == 2'd2) m_lc = bus_din;
         else if (bus_din[7]) begin
            if (bus_din[6:5] == 0 && bus_din[2] == 0) begin
               m_ia = bus_din[4]; m_icu = bus_din[3];
               m_ib = bus_din[1]; m_icl = bus_din[0];
               m_la = 0; m_lb = 0; m_lc = 0;
            end
         end else begin
            m_lc[bus_din[3:1]] = bus_din[0];
         end
      end
   end

   function automatic bit [7:0] exp_read(input bit [1:0] a);
      bit [7:0] r;
      case (a)
         2'd0: r = m_ia ? pa_in : m_la;
         2'd1: r = m_ib ? pb_in : m_lb;
         2'd2: begin
            r[7:4] = m_icu ? pc_in[7:4] : m_lc[7:4];
            r[3:0] = m_icl ? pc_in[3:0] : m_lc[3:0];
         end
         default: r = {1'b1, 2'b00, m_ia, m_icu, 1'b0, m_ib, m_icl};
      endcase
      return r;
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         bit drv;
         drv = (cs_n == 0 && rd_n == 0 && wr_n == 1);
         chk({7'd0, bus_oe}, {7'd0, drv}, "R3 bus_oe");
         chk(bus_dout, drv ? exp_read(addr) : 8'h00, "R1 bus_dout");
         chk(pa_oe, m_ia ? 8'h00 : 8'hFF, "R5 pa_oe");
         chk(pb_oe, m_ib ? 8'h00 : 8'hFF, "R5 pb_oe");
         chk(pc_oe, {m_icu ? 4'h0 : 4'hF, m_icl ? 4'h0 : 4'hF}, "R5 pc_oe");
         chk(pa_out, m_la, "R9 pa_out");
         chk(pb_out, m_lb, "R9 pb_out");
         chk(pc_out, m_lc, "R9 pc_out");
      end
   end

   task automatic idle();
      cs_n = 1; rd_n = 1; wr_n = 1;
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      cs_n = 0; rd_n = 1; wr_n = 0; addr = a; bus_din = d;
      @(posedge clk); #1;
      idle();
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      cs_n = 0; rd_n = 0; wr_n = 1; addr = a;
      @(negedge clk);
      chk(bus_dout, exp, tag);
      @(posedge clk); #1;
      idle();
   endtask

   task automatic at_neg();
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      at_neg();
      // R4 reset state
      chk(pa_oe, 8'h00, "R4 pa_oe");
      chk(pc_oe, 8'h00, "R4 pc_oe");
      chk(pc_out, 8'h00, "R4 pc_out");
      bus_rd(2'd3, 8'h9B, "R4 R10 ctl readback");

      pa_in = 8'h5A; pb_in = 8'hC4; pc_in = 8'hE1;
      bus_rd(2'd0, 8'h5A, "R1 port A pins");
      bus_rd(2'd1, 8'hC4, "R1 port B pins");
      bus_rd(2'd2, 8'hE1, "R2 port C pins");

      bus_wr(2'd3, 8'h80);
      at_neg();
      chk(pa_oe, 8'hFF, "R5 A out");
      chk(pb_oe, 8'hFF, "R5 B out");
      chk(pc_oe, 8'hFF, "R5 C out");
      bus_rd(2'd3, 8'h80, "R10 all outputs");

      bus_wr(2'd0, 8'hC3);
      bus_wr(2'd1, 8'h3C);
      bus_wr(2'd2, 8'hA5);
      at_neg();
      chk(pa_out, 8'hC3, "R9 A latch");
      chk(pc_out, 8'hA5, "R9 C latch");
      bus_rd(2'd0, 8'hC3, "R1 A latch read");
      bus_rd(2'd1, 8'h3C, "R1 B latch read");
      bus_rd(2'd2, 8'hA5, "R2 C latch read");

      bus_wr(2'd3, 8'h80);
      at_neg();
      chk(pa_out, 8'h00, "R6 A cleared");
      chk(pb_out, 8'h00, "R6 B cleared");
      chk(pc_out, 8'h00, "R6 C cleared");

      bus_wr(2'd2, 8'hFF);
      bus_wr(2'd3, 8'h88);
      at_neg();
      chk(pc_out, 8'h00, "R6 C cleared again");
      chk(pc_oe, 8'h0F, "R5 C upper input");
      pc_in = 8'h7E;
      bus_rd(2'd2, 8'h70, "R2 mixed nibbles");
      bus_rd(2'd3, 8'h88, "R10 readback");

      bus_wr(2'd3, 8'h03);
      at_neg(); chk(pc_out, 8'h02, "R7 set bit1");
      bus_wr(2'd3, 8'h0D);
      at_neg(); chk(pc_out, 8'h42, "R7 set bit6");
      bus_wr(2'd3, 8'h02);
      at_neg(); chk(pc_out, 8'h40, "R7 clear bit1");

      bus_wr(2'd3, 8'hA0);
      bus_wr(2'd3, 8'h84);
      at_neg();
      chk(pc_oe, 8'h0F, "R8 C dir kept");
      chk(pa_oe, 8'hFF, "R8 A dir kept");
      chk(pc_out, 8'h40, "R8 C latch kept");

      // write strobe without chip select
      @(posedge clk); #1;
      cs_n = 1; wr_n = 0; rd_n = 0; addr = 2'd0; bus_din = 8'h77;
      at_neg(); chk({7'd0, bus_oe}, 8'h00, "R3 no cs");
      @(posedge clk); #1; idle();
      at_neg(); chk(pa_out, 8'h00, "R9 no cs no write");

      // both strobes low: write happens, bus not driven
      @(posedge clk); #1;
      cs_n = 0; wr_n = 0; rd_n = 0; addr = 2'd0; bus_din = 8'h99;
      at_neg(); chk({7'd0, bus_oe}, 8'h00, "R3 both strobes");
      @(posedge clk); #1; idle();
      at_neg(); chk(pa_out, 8'h99, "R9 write with rd low");

      bus_wr(2'd3, 8'h9B);
      at_neg(); chk(pa_oe, 8'h00, "R5 back to input");
      pa_in = 8'h5A;
      bus_rd(2'd0, 8'h5A, "R1 input after mode");

      for (int i = 0; i < 400; i++) begin
         @(posedge clk); #1;
         cs_n = $urandom_range(0, 3) == 0;
         rd_n = $urandom_range(0, 1) != 0;
         wr_n = $urandom_range(0, 2) != 0;
         addr = 2'($urandom_range(0, 3));
         bus_din = 8'($urandom);
         pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      end
      @(posedge clk); #1; idle();
      at_neg();
      finish_run();
   end
endmodule